// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Controller

This block arbitrates seven interrupt request lines for an 8-bit CPU and gives the CPU one vector address at a time. The seven lines are two external request flags, two timer overflow flags, a serial request, an output-buffer event and an input-buffer event. The serial request is the OR of a receive flag and a transmit flag. An enable register holds one enable bit per source and a global enable bit. A priority register places each source at either the low level or the high level. The controller samples the sources once per machine cycle, on each `tick` strobe.

A request that wins arbitration is latched. The controller then drives `irq_req` and a vector, and holds both unchanged until the CPU pulses `irq_ack`. On the acknowledge, the controller marks the level of that request as in service. For an acknowledged timer source, and for an external source in edge mode, it also sends a one-cycle clear pulse back to that source. A return pulse from the CPU ends the active handler at the highest level that is in service.

Two in-service bits give one level of nesting. A high-level request can interrupt a running low-level handler. A request at the same level or at a lower level waits until the handler returns.

Top module: `irq_ctrl7`

## Requirements
- R1: After reset, `en_q` and `pri_q` read 00h, `irq_req` is 0, `in_service` is 00 and `flag_clr` is 0000.
- R2: When enable bit 7 (global) is 0, no request is raised. When it is 1, a source is considered only if its own enable bit is set. The enable bits 0..6 map to ext0, tmr0, ext1, tmr1, serial, input-buffer and output-buffer.
- R3: Within one level, the winner follows the order ext0, tmr0, ext1, tmr1, output-buffer, serial, input-buffer. The vectors are 03h, 0Bh, 13h, 1Bh, 33h, 23h and 2Bh respectively.
- R4: An enabled high-level request (its priority bit is 1; the bit positions are the same as the enable bits) wins over any low-level request, whatever their places in the polling order.
- R5: While `irq_req` is 1 and no acknowledge has come, `irq_req` and `irq_vec` stay unchanged even if the sources change and `tick` pulses.
- R6: An acknowledge sets `in_service[1]` for a high request or `in_service[0]` for a low request. When `in_service` is 01, only high requests can be raised. When `in_service[1]` is 1, no request is raised.
- R7: A pulse on `irq_ret` clears the highest set bit of `in_service`.
- R8: One cycle after an acknowledge, `flag_clr` pulses the bit of the acknowledged source. The bits are [0] ext0, [1] tmr0, [2] ext1, [3] tmr1, and an external source gets the pulse only when its edge-mode input is 1. For serial and buffer sources, `flag_clr` stays 0000.
- R9: The serial source is requested when either `ser_rx` or `ser_tx` is 1.
- R10: Priority bit 7 is reserved. It always reads 0.
- R11: Sources are sampled only in cycles where `tick` is 1.
- R12: When `irq_ack` and `irq_ret` come in the same cycle, the return is applied first and the acknowledged level is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle sampling strobe |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Priority register write strobe |
| pri_wdata | input | 8 | Priority register write data |
| en_q | output | 8 | Enable register value |
| pri_q | output | 8 | Priority register value |
| ext0_req | input | 1 | External request 0 flag |
| ext0_edge | input | 1 | External 0 is edge mode |
| tmr0_req | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External request 1 flag |
| ext1_edge | input | 1 | External 1 is edge mode |
| tmr1_req | input | 1 | Timer 1 overflow flag |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| ibuf_req | input | 1 | Input buffer full flag |
| obuf_req | input | 1 | Output buffer event flag |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_ret | input | 1 | CPU return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_vec | output | 8 | Vector address |
| in_service | output | 2 | In-service bits [1] high, [0] low |
| flag_clr | output | 4 | Clear pulses for ext0, tmr0, ext1, tmr1 |

## Verification
An acknowledge and a return can fall in the same cycle. This happens when a high-level request pre-empts a low handler just as that handler exits. The bench sets up this case: it leaves a low handler in service, latches a high request, and then pulses `irq_ack` and `irq_ret` together. It expects `in_service` to become 10 and the timer clear pulse to follow one cycle later. The bench also checks that a tick arriving while a vector is held does not replace that vector.

// File: rtl/irq_ctrl7.sv
module irq_ctrl7 #(
  parameter int NSRC = 7,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h03,
  parameter int VEC_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_we,
  input  logic [7:0]    en_wdata,
  input  logic          pri_we,
  input  logic [7:0]    pri_wdata,
  output logic [7:0]    en_q,
  output logic [7:0]    pri_q,
  input  logic          ext0_req,
  input  logic          ext0_edge,
  input  logic          tmr0_req,
  input  logic          ext1_req,
  input  logic          ext1_edge,
  input  logic          tmr1_req,
  input  logic          ser_rx,
  input  logic          ser_tx,
  input  logic          ibuf_req,
  input  logic          obuf_req,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  output logic [1:0]    in_service,
  output logic [3:0]    flag_clr
);
  localparam int IW = $clog2(NSRC);

  logic [7:0]      en_r;
  logic [NSRC-1:0] pri_r;
  logic            req_q, lvl_q;
  logic [IW-1:0]   idx_q;
  logic [1:0]      isv;

  function automatic logic [IW-1:0] pick(input logic [NSRC-1:0] m);
    if (m[0])      pick = IW'(0);
    else if (m[1]) pick = IW'(1);
    else if (m[2]) pick = IW'(2);
    else if (m[3]) pick = IW'(3);
    else if (m[6]) pick = IW'(6);
    else if (m[4]) pick = IW'(4);
    else           pick = IW'(5);
  endfunction

  wire [NSRC-1:0] src  = {obuf_req, ibuf_req, ser_rx | ser_tx, tmr1_req, ext1_req, tmr0_req, ext0_req};
  wire [NSRC-1:0] pend = src & en_r[NSRC-1:0] & {NSRC{en_r[7]}};
  wire [NSRC-1:0] hi   = pend & pri_r;
  wire [NSRC-1:0] lo   = pend & ~pri_r;
  wire hi_ok = (|hi) && !isv[1];
  wire lo_ok = (|lo) && (isv == 2'b00);
  wire [IW-1:0] win_idx = hi_ok ? pick(hi) : pick(lo);
  wire take   = tick && !req_q && !irq_ack && (hi_ok || lo_ok);
  wire ack_ok = irq_ack && req_q;

  logic [1:0] isv_ret, isv_nxt;
  logic [3:0] clr_nxt;

  always_comb begin
    isv_ret = isv;
    if (irq_ret) isv_ret = isv[1] ? {1'b0, isv[0]} : 2'b00;
    isv_nxt = isv_ret;
    if (ack_ok) isv_nxt = isv_ret | (lvl_q ? 2'b10 : 2'b01);
    clr_nxt = 4'b0000;
    if (ack_ok) begin
      case (idx_q)
        IW'(0): clr_nxt = {3'b000, ext0_edge};
        IW'(1): clr_nxt = 4'b0010;
        IW'(2): clr_nxt = {1'b0, ext1_edge, 2'b00};
        IW'(3): clr_nxt = 4'b1000;
        default: clr_nxt = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r <= '0; pri_r <= '0;
      req_q <= 1'b0; lvl_q <= 1'b0; idx_q <= '0;
      isv <= 2'b00; flag_clr <= 4'b0000;
    end else begin
      if (en_we)  en_r  <= en_wdata;
      if (pri_we) pri_r <= pri_wdata[NSRC-1:0];
      if (ack_ok) req_q <= 1'b0;
      else if (take) begin
        req_q <= 1'b1;
        lvl_q <= hi_ok;
        idx_q <= win_idx;
      end
      isv      <= isv_nxt;
      flag_clr <= clr_nxt;
    end
  end

  assign en_q       = en_r;
  assign pri_q      = {1'b0, pri_r};
  assign irq_req    = req_q;
  assign irq_vec    = VEC_BASE + VW'(VEC_STEP) * VW'(idx_q);
  assign in_service = isv;

  p_hold_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));
  p_global_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !en_q[7]) |=> !irq_req);
  p_no_raise_high_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && in_service[1]) |=> !irq_req);
  p_sample_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !tick) |=> !irq_req);
  p_ret_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && in_service != 2'b00) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));
  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr));
  p_clr_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req) |=> (flag_clr == 4'b0000));
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_q[7]);
endmodule

// File: tb/irq_ctrl7_tb_top.sv
module irq_ctrl7_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic en_we = 1'b0, pri_we = 1'b0;
  logic [7:0] en_wdata = '0, pri_wdata = '0;
  logic ext0_req = 0, ext0_edge = 0, tmr0_req = 0, ext1_req = 0, ext1_edge = 0, tmr1_req = 0;
  logic ser_rx = 0, ser_tx = 0, ibuf_req = 0, obuf_req = 0, irq_ack = 0, irq_ret = 0;
  logic [7:0] en_q, pri_q, irq_vec;
  logic irq_req;
  logic [1:0] in_service;
  logic [3:0] flag_clr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl7 dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .en_q(en_q), .pri_q(pri_q),
    .ext0_req(ext0_req), .ext0_edge(ext0_edge), .tmr0_req(tmr0_req),
    .ext1_req(ext1_req), .ext1_edge(ext1_edge), .tmr1_req(tmr1_req),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .ibuf_req(ibuf_req), .obuf_req(obuf_req),
    .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .in_service(in_service), .flag_clr(flag_clr)
  );

  // en, pri, src{obuf,ibuf,ser,tmr1,ext1,tmr0,ext0}, exp_req, exp_vec
  localparam logic [32:0] TBL [12] = '{
    {8'h7F, 8'h00, 8'h7F, 1'b0, 8'h00},  // R2 global off
    {8'hFF, 8'h00, 8'h7F, 1'b1, 8'h03},  // R3
    {8'hFF, 8'h00, 8'h7E, 1'b1, 8'h0B},  // R3
    {8'hFF, 8'h00, 8'h7C, 1'b1, 8'h13},  // R3
    {8'hFF, 8'h00, 8'h78, 1'b1, 8'h1B},  // R3
    {8'hFF, 8'h00, 8'h70, 1'b1, 8'h33},  // R3 obuf before serial
    {8'hFF, 8'h00, 8'h30, 1'b1, 8'h23},  // R3
    {8'hFF, 8'h00, 8'h20, 1'b1, 8'h2B},  // R3
    {8'hFF, 8'h20, 8'h7F, 1'b1, 8'h2B},  // R4
    {8'hFE, 8'h00, 8'h01, 1'b0, 8'h00},  // R2 own enable off
    {8'hFF, 8'h08, 8'h0F, 1'b1, 8'h1B},  // R4
    {8'h9F, 8'h00, 8'h60, 1'b0, 8'h00}   // R2
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [6:0] s);
    ext0_req = s[0]; tmr0_req = s[1]; ext1_req = s[2]; tmr1_req = s[3];
    ser_rx = s[4]; ser_tx = 1'b0; ibuf_req = s[5]; obuf_req = s[6];
  endtask

  task automatic wr(input logic [7:0] e, input logic [7:0] p);
    en_we = 1; pri_we = 1; en_wdata = e; pri_wdata = p;
    step();
    en_we = 0; pri_we = 0;
  endtask

  task automatic do_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic pulse(input logic a, input logic r);
    irq_ack = a; irq_ret = r; step(); irq_ack = 0; irq_ret = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R1 irq_req", {7'b0, irq_req}, 8'h00);
    chk("R1 en_q", en_q, 8'h00);
    chk("R1 pri_q", pri_q, 8'h00);
    chk("R1 in_service", {6'b0, in_service}, 8'h00);
    chk("R1 flag_clr", {4'b0, flag_clr}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][32:25], TBL[i][24:17]);
      set_src(TBL[i][15:9]);
      do_tick();
      chk($sformatf("R2/R3/R4 row%0d req", i), {7'b0, irq_req}, {7'b0, TBL[i][8]});
      if (TBL[i][8]) begin
        chk($sformatf("R3/R4 row%0d vec", i), irq_vec, TBL[i][7:0]);
        pulse(1, 0);
        pulse(0, 1);
      end
      set_src(7'h00);
      step();
    end

    wr(8'hFF, 8'hFF);
    chk("R10 reserved bit", pri_q, 8'h7F);
    wr(8'hFF, 8'h00);
    chk("R2 en readback", en_q, 8'hFF);

    ext0_edge = 1; ext1_edge = 1;
    set_src(7'h04);
    step(); step(); step();
    chk("R11 no tick", {7'b0, irq_req}, 8'h00);
    do_tick();
    chk("R11 tick req", {7'b0, irq_req}, 8'h01);
    chk("R3 ext1 vec", irq_vec, 8'h13);
    set_src(7'h05);
    do_tick();
    chk("R5 held vec", irq_vec, 8'h13);
    chk("R5 held req", {7'b0, irq_req}, 8'h01);
    pulse(1, 0);
    chk("R6 low in service", {6'b0, in_service}, 8'h01);
    chk("R8 ext1 edge clr", {4'b0, flag_clr}, 8'h04);
    set_src(7'h01);
    do_tick();
    chk("R6 low waits", {7'b0, irq_req}, 8'h00);

    wr(8'hFF, 8'h02);
    set_src(7'h03);
    do_tick();
    chk("R6 preempt req", {7'b0, irq_req}, 8'h01);
    chk("R6 preempt vec", irq_vec, 8'h0B);
    pulse(1, 1);
    chk("R12 ack+ret", {6'b0, in_service}, 8'h02);
    chk("R8 tmr0 clr", {4'b0, flag_clr}, 8'h02);
    do_tick();
    chk("R6 high busy blocks", {7'b0, irq_req}, 8'h00);
    pulse(0, 1);
    chk("R7 ret high", {6'b0, in_service}, 8'h00);
    do_tick();
    chk("R4 high over ext0", irq_vec, 8'h0B);
    pulse(1, 0);
    pulse(0, 1);

    wr(8'hFF, 8'h00);
    set_src(7'h01);
    do_tick();
    chk("R3 ext0 vec", irq_vec, 8'h03);
    pulse(1, 0);
    chk("R8 ext0 edge clr", {4'b0, flag_clr}, 8'h01);
    wr(8'hFF, 8'h02);
    set_src(7'h02);
    do_tick();
    pulse(1, 0);
    chk("R6 nested", {6'b0, in_service}, 8'h03);
    pulse(0, 1);
    chk("R7 clears high first", {6'b0, in_service}, 8'h01);
    pulse(0, 1);
    chk("R7 clears low", {6'b0, in_service}, 8'h00);

    wr(8'hFF, 8'h00);
    set_src(7'h00);
    ser_tx = 1;
    do_tick();
    chk("R9 tx alone", irq_vec, 8'h23);
    pulse(1, 0);
    chk("R8 serial no clr", {4'b0, flag_clr}, 8'h00);
    pulse(0, 1);
    ser_tx = 0;

    ext0_edge = 0;
    set_src(7'h01);
    do_tick();
    pulse(1, 0);
    chk("R8 level ext0 no clr", {4'b0, flag_clr}, 8'h00);
    pulse(0, 1);
    set_src(7'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule